// File: doc/BRIEF.md
# ADC Output Code Formatter

This block sits after a 10-bit data converter and re-codes each sample. Samples arrive as offset-binary words. The block sends each one out as offset binary, two's complement or Gray code. A three-bit select field, held in a configuration register, picks the coding. When that field asks for pin control, the coding comes from a board strap that has three levels. The strap is delivered to the block already decoded into a two-bit level code.

Samples come in and go out over valid/ready streams. A sample is accepted on a rising clock edge where `s_valid` and `s_ready` are both high. The recoded word appears on `m_data` with `m_valid` high after that same edge. It stays there, unchanged, until a rising edge where `m_ready` is high. `s_ready` is high whenever the output slot is empty or is being drained in the same cycle, and low during a soft reset. The upstream side may therefore stall for any number of cycles, and the downstream side may apply back-pressure for any number of cycles. A soft reset empties the output slot but keeps the format register. A hard reset clears both.

Top module: `adc_code_formatter`

## Requirements
- R1: While `rst_n` is low, and on the cycle after any cycle with `soft_rst` high, `m_valid` is 0. A hard reset sets the format register to 000.
- R2: With select code 100 (offset binary), `m_data` equals the accepted input word.
- R3: With select code 001 (two's complement), `m_data` is the input with bit 9 inverted and bits 8..0 unchanged. This equals the input minus 512, modulo 1024.
- R4: With select code 010 (Gray), output bit 9 equals input bit 9, and each output bit i below that is input bit i XOR input bit i+1.
- R5: With select code 000, the strap decides the coding. `strap_lvl` 00 (low) gives offset binary, 01 (mid) gives two's complement, 10 (high) gives Gray, and 11 is read as low.
- R6: Select codes 011, 101, 110 and 111 behave exactly as 000, so the strap decides the coding.
- R7: A sample accepted on an edge is on `m_data` with `m_valid` high right after that edge. It is one cycle of latency.
- R8: While `m_valid` is high and `m_ready` is low (with no soft reset), `m_valid` stays high and `m_data` holds its value. `s_ready` equals (not `soft_rst`) and (not `m_valid` or `m_ready`).
- R9: A soft reset leaves the format register unchanged. Samples accepted after it use the format written before it.
- R10: A `cfg_we` write takes effect for samples accepted on later edges. A sample accepted on the same edge as the write still uses the old format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Hard reset, active low, synchronous |
| soft_rst | input | 1 | Soft reset: empties the output slot, keeps the format register |
| strap_lvl | input | 2 | Decoded strap level: 00 low, 01 mid, 10 high |
| cfg_we | input | 1 | Write strobe for the format register |
| cfg_sel | input | 3 | Format select value to write |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_data | input | 10 | Offset-binary input sample |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream accepts the output sample |
| m_data | output | 10 | Recoded output sample |

## Verification
The assertions assume that `s_data` is a defined value whenever `s_valid` is high. They also assume that `rst_n` is held low long enough for the first rising edge to clear the output slot. Stall checks drop their claim in any cycle where a soft reset is active, because a soft reset is allowed to empty a stalled slot. The stimulus changes inputs only just after a rising edge and keeps them steady up to the next edge. It starts every run with several cycles of hard reset. Beside random words, the stimulus draws data from the code extremes and the midpoint: 0, 1, 511, 512 and 1023.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
  // Coding applied to the output word
  typedef enum logic [1:0] {
    FMT_OFFBIN = 2'd0,
    FMT_TWOS   = 2'd1,
    FMT_GRAY   = 2'd2
  } ocf_fmt_e;

  // One-hot select values of the format register; anything else means strap control
  localparam logic [2:0] SEL_PIN    = 3'b000;
  localparam logic [2:0] SEL_TWOS   = 3'b001;
  localparam logic [2:0] SEL_GRAY   = 3'b010;
  localparam logic [2:0] SEL_OFFBIN = 3'b100;

  // Decoded strap level codes
  localparam logic [1:0] STRAP_LOW  = 2'b00;
  localparam logic [1:0] STRAP_MID  = 2'b01;
  localparam logic [1:0] STRAP_HIGH = 2'b10;
endpackage

// File: rtl/ocf_strap_decode.sv
module ocf_strap_decode
  import ocf_pkg::*;
(
  input  logic [1:0] strap_lvl,
  output ocf_fmt_e   strap_fmt
);
  always_comb begin
    unique case (strap_lvl)
      STRAP_MID:  strap_fmt = FMT_TWOS;
      STRAP_HIGH: strap_fmt = FMT_GRAY;
      default:    strap_fmt = FMT_OFFBIN;  // low, and the unused code
    endcase
  end
endmodule

// File: rtl/ocf_fmt_resolve.sv
module ocf_fmt_resolve
  import ocf_pkg::*;
(
  input  logic [2:0] sel,
  input  ocf_fmt_e   strap_fmt,
  output ocf_fmt_e   eff_fmt
);
  always_comb begin
    unique case (sel)
      SEL_TWOS:   eff_fmt = FMT_TWOS;
      SEL_GRAY:   eff_fmt = FMT_GRAY;
      SEL_OFFBIN: eff_fmt = FMT_OFFBIN;
      default:    eff_fmt = strap_fmt;  // pin control and unlisted codes
    endcase
  end
endmodule

// File: rtl/ocf_code_conv.sv
module ocf_code_conv
  import ocf_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] in_word,
  input  ocf_fmt_e     fmt,
  output logic [W-1:0] out_word
);
  localparam int MSB = W - 1;

  logic [W-1:0] twos_word;
  logic [W-1:0] gray_word;

  assign twos_word = {~in_word[MSB], in_word[MSB-1:0]};

  assign gray_word[MSB] = in_word[MSB];
  for (genvar i = 0; i < MSB; i++) begin : g_gray
    assign gray_word[i] = in_word[i] ^ in_word[i+1];
  end

  always_comb begin
    unique case (fmt)
      FMT_TWOS: out_word = twos_word;
      FMT_GRAY: out_word = gray_word;
      default:  out_word = in_word;
    endcase
  end
endmodule

// File: rtl/ocf_out_stage.sv
module ocf_out_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !flush && (!out_valid || out_ready);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (take) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/adc_code_formatter.sv
module adc_code_formatter
  import ocf_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [1:0]   strap_lvl,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_sel,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic [2:0]   cfg_q;
  ocf_fmt_e     strap_fmt;
  ocf_fmt_e     eff_fmt;
  logic [W-1:0] conv_word;

  // Format register: only the hard reset clears it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= SEL_PIN;
    end else if (cfg_we) begin
      cfg_q <= cfg_sel;
    end
  end

  ocf_strap_decode u_strap (
    .strap_lvl (strap_lvl),
    .strap_fmt (strap_fmt)
  );

  ocf_fmt_resolve u_resolve (
    .sel       (cfg_q),
    .strap_fmt (strap_fmt),
    .eff_fmt   (eff_fmt)
  );

  ocf_code_conv #(.W(W)) u_conv (
    .in_word  (s_data),
    .fmt      (eff_fmt),
    .out_word (conv_word)
  );

  ocf_out_stage #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (soft_rst),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   (conv_word),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (m_data)
  );
endmodule

// File: rtl/ocf_chk.sv
module ocf_chk
  import ocf_pkg::*;
#(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         soft_rst,
  input logic         cfg_we,
  input logic [2:0]   cfg_q,
  input ocf_fmt_e     eff_fmt,
  input logic         s_valid,
  input logic         s_ready,
  input logic [W-1:0] s_data,
  input logic         m_valid,
  input logic         m_ready,
  input logic [W-1:0] m_data
);
  logic acc;
  assign acc = s_valid && s_ready;

  // R1
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !m_valid);

  // R7
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> m_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !soft_rst) |=> (m_valid && $stable(m_data)));

  // R2
  offbin_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && eff_fmt == FMT_OFFBIN) |=> (m_data == $past(s_data)));

  // R3
  twos_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && eff_fmt == FMT_TWOS) |=>
      (m_data[W-1] != $past(s_data[W-1]) && m_data[W-2:0] == $past(s_data[W-2:0])));

  // R4
  gray_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && eff_fmt == FMT_GRAY) |=>
      (m_data[W-1] == $past(s_data[W-1]) && m_data[0] == ^$past(s_data[1:0])));

  // R9
  soft_keep_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !cfg_we) |=> $stable(cfg_q));
endmodule

bind adc_code_formatter ocf_chk #(.W(W)) u_ocf_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (soft_rst),
  .cfg_we   (cfg_we),
  .cfg_q    (cfg_q),
  .eff_fmt  (eff_fmt),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .s_data   (s_data),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_data   (m_data)
);

// File: tb/test_adc_code_formatter.sv
`timescale 1ns/1ps
module test_adc_code_formatter;
  localparam int W = 10;
  localparam int SPAN = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         soft_rst = 1'b0;
  logic [1:0]   strap_lvl = 2'b00;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_sel = 3'b000;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [W-1:0] s_data = '0;
  logic         m_valid;
  logic         m_ready = 1'b0;
  logic [W-1:0] m_data;

  always #2.5 clk = ~clk;

  adc_code_formatter #(.W(W)) i_adc_code_formatter (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .strap_lvl(strap_lvl),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string req = "R1";

  // reference state
  bit ref_mv = 1'b0;
  int ref_md = 0;
  int ref_sel = 0;

  // 0 offset binary, 1 two's complement, 2 Gray
  function automatic int pick_fmt(int sel, int strap);
    if (sel == 1) return 1;
    if (sel == 2) return 2;
    if (sel == 4) return 0;
    if (strap == 1) return 1;
    if (strap == 2) return 2;
    return 0;
  endfunction

  function automatic int recode(int x, int f);
    int g;
    if (f == 1) return (x + HALF) % SPAN;
    if (f == 2) begin
      g = 0;
      for (int i = 0; i < W; i++) begin
        if (((x / (1 << i)) % 2) != ((x / (1 << (i + 1))) % 2)) g += (1 << i);
      end
      return g;
    end
    return x;
  endfunction

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit rdy;
    bit acc;
    int nxt_md;
    #1;
    rdy = !soft_rst && (!ref_mv || m_ready);
    check("s_ready", int'(s_ready), int'(rdy));
    acc = s_valid && rdy;
    nxt_md = recode(int'(s_data), pick_fmt(ref_sel, int'(strap_lvl)));
    @(posedge clk);
    if (!rst_n) begin
      ref_mv = 1'b0;
      ref_sel = 0;
    end else begin
      if (soft_rst) ref_mv = 1'b0;
      else if (acc) begin ref_mv = 1'b1; ref_md = nxt_md; end
      else if (m_ready) ref_mv = 1'b0;
      if (cfg_we) ref_sel = int'(cfg_sel);
    end
    #1;
    check("m_valid", int'(m_valid), int'(ref_mv));
    if (ref_mv) check("m_data", int'(m_data), ref_md);
    cfg_we = 1'b0;
    soft_rst = 1'b0;
  endtask

  function automatic logic [W-1:0] pick_word();
    case ($urandom_range(0, 7))
      0: return '0;
      1: return W'(1);
      2: return W'(HALF - 1);
      3: return W'(HALF);
      4: return '1;
      default: return W'($urandom_range(0, SPAN - 1));
    endcase
  endfunction

  task automatic stream(int n, int ready_pct);
    for (int k = 0; k < n; k++) begin
      s_valid = ($urandom_range(0, 99) < 80);
      s_data  = pick_word();
      m_ready = ($urandom_range(0, 99) < ready_pct);
      step();
    end
  endtask

  task automatic write_sel(logic [2:0] v);
    cfg_sel = v;
    cfg_we  = 1'b1;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    req = "R1";
    repeat (4) step();
    rst_n = 1'b1;
    step();

    // R5: strap control with register at 000 after reset
    req = "R5";
    for (int s = 0; s < 4; s++) begin
      strap_lvl = 2'(s);
      stream(40, 90);
    end

    // R2 / R3 / R4: register selects
    req = "R2"; write_sel(3'b100); strap_lvl = 2'b10; stream(60, 90);
    req = "R3"; write_sel(3'b001); strap_lvl = 2'b00; stream(60, 90);
    req = "R4"; write_sel(3'b010); strap_lvl = 2'b01; stream(60, 90);

    // R6: unlisted codes fall back to strap
    req = "R6";
    for (int c = 3; c < 8; c++) begin
      if (c == 4) continue;
      write_sel(3'(c));
      for (int s = 0; s < 3; s++) begin
        strap_lvl = 2'(s);
        stream(15, 90);
      end
    end

    // R8 and R7: heavy back-pressure
    req = "R8"; write_sel(3'b001); stream(120, 30);
    req = "R7"; stream(60, 100);

    // R10: write on the same edge as an accept
    req = "R10";
    s_valid = 1'b1; m_ready = 1'b1; s_data = W'(HALF + 3);
    step();
    s_data = W'(HALF - 2); cfg_sel = 3'b010; cfg_we = 1'b1;
    step();
    s_data = W'(HALF - 2);
    step();
    stream(30, 80);

    // R9: soft reset keeps format, empties output
    req = "R9";
    write_sel(3'b100);
    strap_lvl = 2'b01;
    s_valid = 1'b1; m_ready = 1'b0; s_data = W'(77);
    step();
    soft_rst = 1'b1; s_valid = 1'b1;
    step();
    soft_rst = 1'b1;
    step();
    stream(60, 70);

    // R1: hard reset clears register back to strap control
    req = "R1";
    rst_n = 1'b0; s_valid = 1'b0;
    step(); step();
    rst_n = 1'b1;
    strap_lvl = 2'b01;
    stream(40, 80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule